// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers error and event causes into two stacked levels of interrupt groups and reduces them to one interrupt line and one engine-abort line. The upper (primary) level has four groups, A to D, each with 32 cause bits. The lower (secondary) level has up to three groups that hold individual fault causes: transmit-direction errors (A), receive-direction errors (B) and shared fabric FIFO parity (C). Each secondary group's pending summary is mirrored into a fixed cause bit of primary group D. That bit is the funnel through which a secondary cause can reach the interrupt line. Secondary group C exists only on revision 4 or later of the surrounding silicon, selected by a revision input.

Every group has the same register window: a cause register cleared by writing 1, a cause-set port, a mask (1 = masked), a mask-clear port, a read-only pending view, a control word and an abort mask (1 = no abort). The control word selects rising-edge or level capture and whether the group's summary joins the interrupt line. One register bus reaches both levels through a small access state machine. BUS_IDLE waits for a request and goes to BUS_ACCESS when one arrives, capturing the address, direction and data. BUS_ACCESS performs the write or samples the read data and always goes to BUS_DONE. BUS_DONE raises the acknowledge for one cycle and always returns to BUS_IDLE.

Software brings the block up in this order: configure the control words, arm the abort masks, unmask the secondary causes, and finally unmask the funnel bits of primary group D.

Top module: `irq_funnel_aggr`

## Requirements
- R1: A request with `bus_req`=1 seen in BUS_IDLE at a rising clock edge gives `bus_ack`=1 for exactly one cycle, starting two edges later. A write takes effect at the second edge. For a read, `bus_rdata` carries the register value while `bus_ack` is high.
- R2: Primary group g (0..3) occupies byte offset g*0x40. Secondary group g (0=A, 1=B, 2=C) occupies 0x2000+g*0x40. Within a group the word offsets are: 0x00 cause, 0x04 cause-set, 0x08 mask, 0x0C mask-clear, 0x10 pending, 0x14 control, 0x18 abort mask.
- R3: The following read as 0 and ignore writes: primary slots 4..15, the range 0x400..0x1FFF, secondary slots from 3 upward, addresses not aligned to 4 bytes, and secondary group C while the revision is below 4.
- R4: Control bit 0 = 1 latches a cause bit when its source rises from 0 to 1. Control bit 0 = 0 latches the bit in every cycle the source is high. A latched bit stays set until a 1 is written to it at offset 0x00. When a source capture and a clear hit the same bit in the same cycle, the capture wins.
- R5: At reset, mask and abort mask are all ones and cause and control are 0. Writing to 0x04 sets the cause bits written as 1. Writing to 0x08 loads the mask. Writing to 0x0C clears the mask bits written as 1. Reads of 0x04 and 0x0C return 0.
- R6: The pending register is cause AND NOT mask. A group's summary is the OR of its pending bits.
- R7: Bits 8, 9 and 10 of primary group D mirror the summaries of secondary groups A, B and C with no latching. Writes through 0x00 or 0x04 do not change them.
- R8: Secondary group C is valid only when `rev_id` >= 4. Below that, primary D bit 10 is 0 and group C contributes nothing.
- R9: `irq_o` is the OR of the summaries of those primary groups whose control bit 1 is 1.
- R10: `abort_o` is the OR, over the valid secondary groups, of any cause bit whose abort-mask bit is 0.
- R11: A secondary cause raises `irq_o` only when it is unmasked in its secondary group, its funnel bit is unmasked in primary D, and D's control bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rev_id | input | 8 | Silicon revision value |
| pri_src | input | 128 | Cause sources of primary groups A..D, 32 bits each (D bits 8..10 unused) |
| sec_src | input | 96 | Cause sources of secondary groups A..C, 32 bits each |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access complete, one cycle |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| irq_o | output | 1 | Aggregated interrupt |
| abort_o | output | 1 | Engine abort request |

## Verification
A wrong capture or mask bit in one group shows up at the next register read of that group's cause or pending word. If it sits on the funnel path, it also moves `irq_o` in the same cycle the secondary cause settles. A broken funnel mirror or revision gate shows on `irq_o` and on the primary D cause readback as soon as a secondary cause is set or the revision input changes. A stuck or skipped state in the access machine shows as a missing, early or doubled `bus_ack` on the next request.

// File: rtl/tlia_pkg.sv
package tlia_pkg;

    localparam int WORD_W    = 4;
    localparam int GRP_SHIFT = 6;

    localparam logic [WORD_W-1:0] W_CAUSE = 4'd0;
    localparam logic [WORD_W-1:0] W_CSET  = 4'd1;
    localparam logic [WORD_W-1:0] W_MASK  = 4'd2;
    localparam logic [WORD_W-1:0] W_MCLR  = 4'd3;
    localparam logic [WORD_W-1:0] W_PEND  = 4'd4;
    localparam logic [WORD_W-1:0] W_CTRL  = 4'd5;
    localparam logic [WORD_W-1:0] W_ABMSK = 4'd6;

    localparam int CTRL_EDGE = 0;
    localparam int CTRL_JOIN = 1;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_ACCESS = 2'd1,
        BUS_DONE   = 2'd2
    } bus_state_t;

endpackage

// File: rtl/tlia_bus_fsm.sv
module tlia_bus_fsm
    import tlia_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_in,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata
);

    bus_state_t        state_q, state_d;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   state_d = req ? BUS_ACCESS : BUS_IDLE;
            BUS_ACCESS: state_d = BUS_DONE;
            BUS_DONE:   state_d = BUS_IDLE;
            default:    state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (state_q == BUS_IDLE && req) begin
                we_q    <= we;
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (state_q == BUS_ACCESS) rdata_q <= we_q ? '0 : rd_in;
        end
    end

    always_comb begin
        ack       = (state_q == BUS_DONE);
        acc_wr    = (state_q == BUS_ACCESS) && we_q;
        acc_addr  = addr_q;
        acc_wdata = wdata_q;
        rdata     = rdata_q;
    end

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R1
    AST_REQ_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_IDLE && req) |=> ##1 ack); // R1

endmodule

// File: rtl/tlia_addr_decode.sv
module tlia_addr_decode
    import tlia_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int N_PRI    = 4,
    parameter int N_SEC    = 3,
    parameter int PRI_SLOTS = 16,
    parameter int SEC_BASE = 'h2000,
    localparam int GW      = $clog2((N_PRI > N_SEC) ? N_PRI : N_SEC)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              sec,
    output logic [GW-1:0]     grp,
    output logic [WORD_W-1:0] word
);

    localparam int GRP_BYTES = 1 << GRP_SHIFT;
    localparam logic [ADDR_W-1:0] PRI_END  = ADDR_W'(PRI_SLOTS * GRP_BYTES);
    localparam logic [ADDR_W-1:0] PRI_USED = ADDR_W'(N_PRI * GRP_BYTES);
    localparam logic [ADDR_W-1:0] SEC_LO   = ADDR_W'(SEC_BASE);
    localparam logic [ADDR_W-1:0] SEC_HI   = ADDR_W'(SEC_BASE + N_SEC * GRP_BYTES);

    logic aligned, pri_win, sec_win;

    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        pri_win = (addr < PRI_END) && (addr < PRI_USED);
        sec_win = (addr >= SEC_LO) && (addr < SEC_HI);
        hit     = aligned && (pri_win || sec_win);
        sec     = sec_win;
        grp     = addr[GRP_SHIFT +: GW];
        word    = addr[2 +: WORD_W];
    end

endmodule

// File: rtl/tlia_irq_group.sv
module tlia_irq_group
    import tlia_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] LIVE_BITS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] src,
    input  logic              wr_stb,
    input  logic              sel,
    input  logic [WORD_W-1:0] word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] cause_o,
    output logic              summary_o,
    output logic              join_o,
    output logic              abort_o
);

    logic [DATA_W-1:0] cause_q, mask_q, abmsk_q, src_q;
    logic [1:0]        ctrl_q;
    logic [DATA_W-1:0] hits, set_vec, clr_vec, sw_set, view, pend;
    logic              wr;

    always_comb begin
        wr      = wr_stb && sel && en;
        hits    = ctrl_q[CTRL_EDGE] ? (src & ~src_q) : src;
        set_vec = en ? (hits & ~LIVE_BITS) : '0;
        clr_vec = (wr && word == W_CAUSE) ? wdata : '0;
        sw_set  = (wr && word == W_CSET)  ? wdata : '0;
        view    = en ? (cause_q | (src & LIVE_BITS)) : '0;
        pend    = view & ~mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '1;
            abmsk_q <= '1;
            ctrl_q  <= '0;
            src_q   <= '0;
        end else begin
            src_q   <= src;
            cause_q <= ((cause_q & ~clr_vec) | sw_set | set_vec) & ~LIVE_BITS;
            if (wr && word == W_MASK)  mask_q  <= wdata;
            if (wr && word == W_MCLR)  mask_q  <= mask_q & ~wdata;
            if (wr && word == W_ABMSK) abmsk_q <= wdata;
            if (wr && word == W_CTRL)  ctrl_q  <= wdata[1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (en) begin
            unique case (word)
                W_CAUSE: rdata = view;
                W_MASK:  rdata = mask_q;
                W_PEND:  rdata = pend;
                W_CTRL:  rdata = {{(DATA_W-2){1'b0}}, ctrl_q};
                W_ABMSK: rdata = abmsk_q;
                default: rdata = '0;
            endcase
        end
    end

    always_comb begin
        cause_o   = view;
        summary_o = |pend;
        join_o    = ctrl_q[CTRL_JOIN];
        abort_o   = |(view & ~abmsk_q);
    end

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ctrl_q[CTRL_EDGE] && |(src & ~src_q & ~LIVE_BITS))
        |=> ((cause_q & $past(src & ~src_q & ~LIVE_BITS)) == $past(src & ~src_q & ~LIVE_BITS))); // R4
    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(cause_q) && $stable(mask_q) && $stable(abmsk_q))); // R3
    AST_MCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word == W_MCLR) |=> ((mask_q & $past(wdata)) == '0)); // R5

endmodule

// File: rtl/irq_funnel_aggr.sv
module irq_funnel_aggr
    import tlia_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 14,
    parameter int REV_W      = 8,
    parameter int N_PRI      = 4,
    parameter int N_SEC      = 3,
    parameter int PRI_SLOTS  = 16,
    parameter int SEC_BASE   = 'h2000,
    parameter int FUNNEL_LSB = 8,
    parameter int GATED_SEC  = 2,
    parameter int C_MIN_REV  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [REV_W-1:0]        rev_id,
    input  logic [N_PRI*DATA_W-1:0] pri_src,
    input  logic [N_SEC*DATA_W-1:0] sec_src,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic                    bus_ack,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    irq_o,
    output logic                    abort_o
);

    localparam int GW     = $clog2((N_PRI > N_SEC) ? N_PRI : N_SEC);
    localparam int D_IDX  = N_PRI - 1;
    localparam logic [DATA_W-1:0] FUNNEL_MASK = DATA_W'(((1 << N_SEC) - 1) << FUNNEL_LSB);

    logic              acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata, rd_in;
    logic              dec_hit, dec_sec;
    logic [GW-1:0]     dec_grp;
    logic [WORD_W-1:0] dec_word;
    logic              c_valid;

    logic [DATA_W-1:0] pri_rd [N_PRI];
    logic [DATA_W-1:0] sec_rd [N_SEC];
    logic [DATA_W-1:0] pri_cause [N_PRI];
    logic [DATA_W-1:0] sec_cause [N_SEC];
    logic [N_PRI-1:0]  pri_sel, pri_sum, pri_join, pri_abort;
    logic [N_SEC-1:0]  sec_sel, sec_sum, sec_join, sec_abort, sec_en;
    logic [DATA_W-1:0] d_src;
    logic              unused_ext_funnel;

    tlia_bus_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rd_in(rd_in), .ack(bus_ack), .rdata(bus_rdata),
        .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata)
    );

    tlia_addr_decode #(.ADDR_W(ADDR_W), .N_PRI(N_PRI), .N_SEC(N_SEC),
                       .PRI_SLOTS(PRI_SLOTS), .SEC_BASE(SEC_BASE)) u_dec (
        .addr(acc_addr), .hit(dec_hit), .sec(dec_sec), .grp(dec_grp), .word(dec_word)
    );

    always_comb begin
        c_valid = (rev_id >= REV_W'(C_MIN_REV));
        d_src   = pri_src[D_IDX*DATA_W +: DATA_W];
        d_src[FUNNEL_LSB +: N_SEC] = sec_sum & sec_en;
        unused_ext_funnel = ^pri_src[D_IDX*DATA_W + FUNNEL_LSB +: N_SEC];
    end

    for (genvar g = 0; g < N_PRI; g++) begin : g_pri
        logic [DATA_W-1:0] g_src;
        assign pri_sel[g] = dec_hit && !dec_sec && (dec_grp == GW'(g));
        if (g == D_IDX) begin : g_funnel
            assign g_src = d_src;
        end else begin : g_plain
            assign g_src = pri_src[g*DATA_W +: DATA_W];
        end
        tlia_irq_group #(.DATA_W(DATA_W),
                         .LIVE_BITS((g == D_IDX) ? FUNNEL_MASK : '0)) u_grp (
            .clk(clk), .rst_n(rst_n), .en(1'b1), .src(g_src),
            .wr_stb(acc_wr), .sel(pri_sel[g]), .word(dec_word), .wdata(acc_wdata),
            .rdata(pri_rd[g]), .cause_o(pri_cause[g]), .summary_o(pri_sum[g]),
            .join_o(pri_join[g]), .abort_o(pri_abort[g])
        );
    end

    for (genvar g = 0; g < N_SEC; g++) begin : g_sec
        if (g == GATED_SEC) begin : g_gate
            assign sec_en[g] = c_valid;
        end else begin : g_open
            assign sec_en[g] = 1'b1;
        end
        assign sec_sel[g] = dec_hit && dec_sec && (dec_grp == GW'(g));
        tlia_irq_group #(.DATA_W(DATA_W), .LIVE_BITS('0)) u_grp (
            .clk(clk), .rst_n(rst_n), .en(sec_en[g]), .src(sec_src[g*DATA_W +: DATA_W]),
            .wr_stb(acc_wr), .sel(sec_sel[g]), .word(dec_word), .wdata(acc_wdata),
            .rdata(sec_rd[g]), .cause_o(sec_cause[g]), .summary_o(sec_sum[g]),
            .join_o(sec_join[g]), .abort_o(sec_abort[g])
        );
    end

    always_comb begin
        rd_in = '0;
        for (int i = 0; i < N_PRI; i++) if (pri_sel[i]) rd_in = rd_in | pri_rd[i];
        for (int i = 0; i < N_SEC; i++) if (sec_sel[i]) rd_in = rd_in | sec_rd[i];
    end

    logic unused_group_side;
    always_comb begin
        unused_group_side = (|pri_abort) ^ (|sec_join) ^ unused_ext_funnel;
        irq_o   = |(pri_sum & pri_join);
        abort_o = |(sec_abort & sec_en);
    end

    logic any_sec_cause;
    always_comb begin
        any_sec_cause = 1'b0;
        for (int i = 0; i < N_SEC; i++) if (sec_en[i]) any_sec_cause = any_sec_cause | (|sec_cause[i]);
    end

    AST_FUNNEL_A: assert property (@(posedge clk) disable iff (!rst_n)
        sec_sum[0] |-> pri_cause[D_IDX][FUNNEL_LSB]); // R7
    AST_C_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !c_valid |-> !pri_cause[D_IDX][FUNNEL_LSB + GATED_SEC]); // R8
    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> any_sec_cause); // R10

endmodule

// File: tb/irq_funnel_aggr_tb.sv
`timescale 1ns/1ps
module irq_funnel_aggr_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   rev_id = 8'd4;
    logic [127:0] pri_src = '0;
    logic [95:0]  sec_src = '0;
    logic         bus_req = 1'b0, bus_we = 1'b0;
    logic [13:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_ack;
    logic [31:0]  bus_rdata;
    logic         irq_o, abort_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic ack_after;

    always #2.5 clk = ~clk;

    irq_funnel_aggr u_dut (
        .clk(clk), .rst_n(rst_n), .rev_id(rev_id), .pri_src(pri_src), .sec_src(sec_src),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .irq_o(irq_o), .abort_o(abort_o)
    );

    function automatic logic [13:0] pa(input int g, input int w);
        return 14'(g * 64 + w * 4);
    endfunction
    function automatic logic [13:0] sa(input int g, input int w);
        return 14'('h2000 + g * 64 + w * 4);
    endfunction
    function automatic logic [31:0] exp_pend(input logic [31:0] c, input logic [31:0] m);
        return c & ~m;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [13:0] a, input logic [31:0] d,
                        output logic [31:0] q);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        while (!bus_ack) @(negedge clk);
        q = bus_rdata;
        @(negedge clk);
        ack_after = bus_ack;
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        logic [31:0] q;
        xfer(1'b1, a, d, q);
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] q);
        xfer(1'b0, a, 32'h0, q);
    endtask

    task automatic pulse_sec(input int g, input logic [31:0] v);
        @(negedge clk); sec_src[g*32 +: 32] = v;
        @(negedge clk); sec_src[g*32 +: 32] = '0;
    endtask

    task automatic pulse_pri(input int g, input logic [31:0] v);
        @(negedge clk); pri_src[g*32 +: 32] = v;
        @(negedge clk); pri_src[g*32 +: 32] = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R9 irq at reset", {31'h0, irq_o}, 32'h0);
        chk("R10 abort at reset", {31'h0, abort_o}, 32'h0);
        rd(pa(0, 2), q); chk("R5 mask reset", q, 32'hFFFF_FFFF);
        chk("R1 ack one cycle", {31'h0, ack_after}, 32'h0);
        rd(pa(0, 5), q); chk("R5 ctrl reset", q, 32'h0);
        rd(sa(0, 6), q); chk("R5 abort mask reset", q, 32'hFFFF_FFFF);

        // Address map holes
        wr(pa(5, 2), 32'h1234);
        rd(pa(5, 2), q); chk("R3 primary slot 5", q, 32'h0);
        rd(14'h1000, q); chk("R3 gap read", q, 32'h0);
        rd(sa(3, 2), q); chk("R3 secondary slot 3", q, 32'h0);
        rd(pa(0, 2) + 14'd1, q); chk("R3 misaligned", q, 32'h0);
        rd(sa(1, 2), q); chk("R2 secondary B mask", q, 32'hFFFF_FFFF);

        // Register semantics on primary B
        wr(pa(1, 2), 32'h0000_F0F0);
        wr(pa(1, 3), 32'h0000_00F0);
        rd(pa(1, 2), q); chk("R5 mask clear", q, 32'h0000_F000);
        rd(pa(1, 3), q); chk("R5 mask clear reads 0", q, 32'h0);
        wr(pa(1, 1), 32'h5);
        rd(pa(1, 0), q); chk("R5 cause set", q, 32'h5);
        wr(pa(1, 0), 32'h1);
        rd(pa(1, 0), q); chk("R4 W1C", q, 32'h4);
        rd(pa(1, 4), q); chk("R6 pending", q, exp_pend(32'h4, 32'h0000_F000));
        wr(pa(1, 0), 32'hFFFF_FFFF);

        // Edge vs level capture on secondary B
        wr(sa(1, 5), 32'h1);
        @(negedge clk); sec_src[32 +: 32] = 32'h1;
        repeat (2) @(negedge clk);
        rd(sa(1, 0), q); chk("R4 edge capture", q, 32'h1);
        wr(sa(1, 0), 32'h1);
        rd(sa(1, 0), q); chk("R4 edge no relatch", q, 32'h0);
        wr(sa(1, 5), 32'h0);
        wr(sa(1, 0), 32'h1);
        rd(sa(1, 0), q); chk("R4 level capture wins", q, 32'h1);
        @(negedge clk); sec_src[32 +: 32] = 32'h0;
        wr(sa(1, 0), 32'h1);
        rd(sa(1, 0), q); chk("R4 clear after release", q, 32'h0);

        // Funnel end to end with secondary A
        wr(sa(0, 3), 32'h8);
        pulse_sec(0, 32'h8);
        rd(pa(3, 0), q); chk("R7 D bit 8 mirror", q, 32'h100);
        chk("R11 D funnel masked", {31'h0, irq_o}, 32'h0);
        wr(pa(3, 3), 32'h100);
        chk("R11 D not joined", {31'h0, irq_o}, 32'h0);
        wr(pa(3, 5), 32'h2);
        chk("R11 full path", {31'h0, irq_o}, 32'h1);
        wr(sa(0, 2), 32'hFFFF_FFFF);
        chk("R11 secondary remask", {31'h0, irq_o}, 32'h0);
        wr(sa(0, 3), 32'h8);
        chk("R9 join restored", {31'h0, irq_o}, 32'h1);
        wr(sa(0, 0), 32'h8);
        chk("R7 mirror drops", {31'h0, irq_o}, 32'h0);
        wr(pa(3, 1), 32'h100);
        rd(pa(3, 0), q); chk("R7 funnel not writable", q, 32'h0);

        // Abort arming
        wr(sa(0, 6), 32'hFFFF_FFF7);
        chk("R10 armed no cause", {31'h0, abort_o}, 32'h0);
        wr(sa(0, 1), 32'h8);
        chk("R10 abort raised", {31'h0, abort_o}, 32'h1);
        wr(sa(0, 0), 32'h8);
        chk("R10 abort cleared", {31'h0, abort_o}, 32'h0);

        // Revision gate on secondary C
        wr(sa(2, 6), 32'hFFFF_FFFE);
        wr(sa(2, 3), 32'h1);
        wr(sa(2, 1), 32'h1);
        rd(sa(2, 0), q); chk("R8 C valid at rev 4", q, 32'h1);
        chk("R10 C abort", {31'h0, abort_o}, 32'h1);
        rd(pa(3, 0), q); chk("R7 D bit 10 mirror", q, 32'h400);
        wr(pa(3, 3), 32'h400);
        chk("R11 C path", {31'h0, irq_o}, 32'h1);
        @(negedge clk); rev_id = 8'd3;
        @(negedge clk);
        chk("R8 irq dark below 4", {31'h0, irq_o}, 32'h0);
        chk("R10 C abort gated", {31'h0, abort_o}, 32'h0);
        rd(sa(2, 0), q); chk("R3 C reads 0", q, 32'h0);
        rd(pa(3, 0), q); chk("R8 D bit 10 zero", q, 32'h0);
        wr(sa(2, 1), 32'h2);
        @(negedge clk); rev_id = 8'd4;
        rd(sa(2, 0), q); chk("R3 C write ignored", q, 32'h1);
        wr(sa(2, 0), 32'h1);
        chk("R11 C cleared", {31'h0, irq_o}, 32'h0);

        // Primary A joins directly
        wr(pa(0, 5), 32'h2);
        wr(pa(0, 3), 32'h1);
        pulse_pri(0, 32'h1);
        chk("R9 primary A joins", {31'h0, irq_o}, 32'h1);
        wr(pa(0, 0), 32'h1);
        chk("R9 primary A cleared", {31'h0, irq_o}, 32'h0);

        // Random capture and pending
        for (int it = 0; it < 24; it++) begin
            int sel;
            logic [31:0] m, v;
            logic [13:0] base;
            sel = int'($urandom_range(4, 0));
            m = $urandom;
            v = $urandom;
            base = (sel < 3) ? pa(sel, 0) : sa(sel - 3, 0);
            wr(base + 14'd8, m);
            wr(base + 14'd20, 32'h0);
            wr(base, 32'hFFFF_FFFF);
            if (sel < 3) pulse_pri(sel, v); else pulse_sec(sel - 3, v);
            rd(base + 14'd16, q); chk("R6 random pending", q, exp_pend(v, m));
            rd(base, q);          chk("R4 random cause", q, v);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule